// File: doc/BRIEF.md
# Event Frame Writer

This block lays out one chip's stored events in a 16-bit-wide SRAM once conversion has finished, so that the data can later be read out in a fixed, predictable shape. A single `start` pulse begins a frame. The block first writes a word holding the 8-bit chip identifier. It then writes one bunch-crossing timestamp word per stored event, fetched through a small timestamp read port. Last come 36 channel words per event, taken from a stream of 12-bit conversion results that carry a hit flag and a gain flag.

Words go to consecutive addresses starting at 0. The channel stream is paced by a valid/ready pair. A cycle with no valid beat inserts a gap in the SRAM writes and does not corrupt the order. When the last word has been written, the block raises `done` for one cycle and presents the number of words written. That count stays on `word_count` until the next frame starts. At most five events are stored, so a full frame is 1 + 5 + 180 = 186 words.

Top module: `evt_frame_writer`

## Requirements
- R1: A `start` seen while the block is idle begins a frame. In the next cycle the block writes address 0 with `chip_id` in bits 7:0 and zeros in bits 15:8. The chip ID is the value present at `start`.
- R2: For stored events e = 0 .. n-1, the block writes the timestamp to address 1+e in consecutive cycles, with no gaps. `ts_addr` equals e in that cycle, and `ts_data` appears in bits 11:0 with bits 15:12 zero.
- R3: The block writes channel words to address 1+n+36·e+c, event by event with channel 0 first, in the order the beats are accepted.
- R4: Each channel word holds the conversion result in bits 11:0, the gain flag in bit 12 and the hit flag in bit 13. Bits 15:14 are zero.
- R5: `adc_ready` is high only in the channel phase. In that phase a write happens in exactly the cycles where `adc_valid` is high, and a low `adc_valid` stalls the frame.
- R6: With zero stored events, only the chip-ID word is written, and `done` follows in the next cycle with `word_count` = 1.
- R7: `done` is high for exactly one cycle, in the cycle right after the last write. At that point `word_count` = 1 + 37·n, and it keeps that value until the next frame starts. No further write occurs.
- R8: A requested event count above 5 is treated as 5, which gives a frame of 186 words.
- R9: A `start` that arrives while a frame is in progress is ignored, and the frame in progress continues unchanged.
- R10: After reset, `mem_we`, `adc_ready` and `done` are low and `word_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (used only when idle) |
| chip_id | input | 8 | Chip identifier, captured at start |
| evt_count | input | 3 | Number of stored events, clamped to 5 |
| ts_addr | output | 3 | Event index for the timestamp read port |
| ts_data | input | 12 | Timestamp of event `ts_addr`, same cycle |
| adc_valid | input | 1 | A channel result is offered |
| adc_value | input | 12 | Conversion result |
| adc_hit | input | 1 | Hit flag of the result |
| adc_gain | input | 1 | Gain-selection flag of the result |
| adc_ready | output | 1 | Channel phase: a valid beat is taken this cycle |
| mem_addr | output | 8 | SRAM write address |
| mem_data | output | 16 | SRAM write data |
| mem_we | output | 1 | SRAM write enable |
| done | output | 1 | One-cycle pulse after the last write |
| word_count | output | 8 | Words written in the last frame |

## Verification
The bench runs frames with 5, 3, 2, 1 and 0 events, and the channel stream is offered in three patterns: always valid, valid every other cycle, and valid four cycles out of five. The continuous pattern tests the address arithmetic at full rate. The two gapped patterns show whether a stall moves a channel word to the wrong address or leaks a write. Distinct data is used for every channel and every timestamp, and the flag bits are varied per beat, so a swapped field, a swapped event or an off-by-one address shows up as a data mismatch. Further frames request 7 events and inject a second `start` mid-frame, which separates correct clamping and busy-ignore behaviour from a restart or an oversized frame.

// File: rtl/evtfw_pkg.sv
package evtfw_pkg;

    localparam int WORD_W = 16;
    localparam int ADC_W  = 12;
    localparam int ID_W   = 8;
    localparam int TS_W   = 12;
    localparam int PAD_W  = WORD_W - ADC_W - 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ID,
        PH_TS,
        PH_CH,
        PH_DONE
    } phase_t;

    typedef struct packed {
        logic             hit;
        logic             gain;
        logic [ADC_W-1:0] value;
    } adc_beat_t;

    typedef struct packed {
        logic [PAD_W-1:0] pad;
        logic             hit;
        logic             gain;
        logic [ADC_W-1:0] value;
    } chan_word_t;

    function automatic logic [WORD_W-1:0] fmt_id(input logic [ID_W-1:0] id);
        return {{(WORD_W-ID_W){1'b0}}, id};
    endfunction

    function automatic logic [WORD_W-1:0] fmt_ts(input logic [TS_W-1:0] ts);
        return {{(WORD_W-TS_W){1'b0}}, ts};
    endfunction

    function automatic logic [WORD_W-1:0] fmt_ch(input adc_beat_t b);
        chan_word_t w;
        w.pad   = '0;
        w.hit   = b.hit;
        w.gain  = b.gain;
        w.value = b.value;
        return w;
    endfunction

endpackage

// File: rtl/evtfw_ctrl.sv
module evtfw_ctrl
    import evtfw_pkg::*;
#(
    parameter int N_CH    = 36,
    parameter int MAX_EVT = 5,
    localparam int EVT_W  = $clog2(MAX_EVT + 1),
    localparam int CH_W   = $clog2(N_CH),
    localparam int ADDR_W = $clog2(1 + MAX_EVT * (N_CH + 1) + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [EVT_W-1:0]  evt_count,
    input  logic              adc_valid,
    output phase_t            phase,
    output logic [EVT_W-1:0]  evt_idx,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              we,
    output logic              adc_ready,
    output logic              done,
    output logic [ADDR_W-1:0] word_count
);

    phase_t            phase_q;
    logic [EVT_W-1:0]  n_q;
    logic [EVT_W-1:0]  evt_q;
    logic [CH_W-1:0]   ch_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] cnt_q;
    logic [EVT_W-1:0]  n_clamped;
    logic              last_evt;

    assign n_clamped = (evt_count > EVT_W'(MAX_EVT)) ? EVT_W'(MAX_EVT) : evt_count;
    assign last_evt  = (evt_q == n_q - 1'b1);

    assign phase      = phase_q;
    assign evt_idx    = evt_q;
    assign wr_addr    = addr_q;
    assign adc_ready  = (phase_q == PH_CH);
    assign we         = (phase_q == PH_ID) || (phase_q == PH_TS) ||
                        ((phase_q == PH_CH) && adc_valid);
    assign done       = (phase_q == PH_DONE);
    assign word_count = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            n_q     <= '0;
            evt_q   <= '0;
            ch_q    <= '0;
            addr_q  <= '0;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        n_q     <= n_clamped;
                        evt_q   <= '0;
                        ch_q    <= '0;
                        addr_q  <= '0;
                        phase_q <= PH_ID;
                    end
                end
                PH_ID: begin
                    addr_q <= addr_q + 1'b1;
                    if (n_q == '0) begin
                        cnt_q   <= addr_q + 1'b1;
                        phase_q <= PH_DONE;
                    end else begin
                        phase_q <= PH_TS;
                    end
                end
                PH_TS: begin
                    addr_q <= addr_q + 1'b1;
                    if (last_evt) begin
                        evt_q   <= '0;
                        phase_q <= PH_CH;
                    end else begin
                        evt_q <= evt_q + 1'b1;
                    end
                end
                PH_CH: begin
                    if (adc_valid) begin
                        addr_q <= addr_q + 1'b1;
                        if (ch_q == CH_W'(N_CH - 1)) begin
                            ch_q <= '0;
                            if (last_evt) begin
                                cnt_q   <= addr_q + 1'b1;
                                phase_q <= PH_DONE;
                            end else begin
                                evt_q <= evt_q + 1'b1;
                            end
                        end else begin
                            ch_q <= ch_q + 1'b1;
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    done_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(we));

    // R5
    stall_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (adc_ready && !adc_valid) |-> !we);

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        ((phase_q == PH_TS || phase_q == PH_CH) && start) |=> (phase_q != PH_ID));

    // R1
    addr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (we && wr_addr == '0) |-> (phase_q == PH_ID));

endmodule

// File: rtl/evtfw_fmt.sv
module evtfw_fmt
    import evtfw_pkg::*;
(
    input  phase_t            phase,
    input  logic [ID_W-1:0]   chip_id,
    input  logic [TS_W-1:0]   ts_data,
    input  adc_beat_t         beat,
    output logic [WORD_W-1:0] word
);

    always_comb begin
        case (phase)
            PH_ID:   word = fmt_id(chip_id);
            PH_TS:   word = fmt_ts(ts_data);
            PH_CH:   word = fmt_ch(beat);
            default: word = '0;
        endcase
    end

endmodule

// File: rtl/evt_frame_writer.sv
module evt_frame_writer
    import evtfw_pkg::*;
#(
    parameter int N_CH    = 36,
    parameter int MAX_EVT = 5,
    localparam int EVT_W  = $clog2(MAX_EVT + 1),
    localparam int ADDR_W = $clog2(1 + MAX_EVT * (N_CH + 1) + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ID_W-1:0]   chip_id,
    input  logic [EVT_W-1:0]  evt_count,
    output logic [EVT_W-1:0]  ts_addr,
    input  logic [TS_W-1:0]   ts_data,
    input  logic              adc_valid,
    input  logic [ADC_W-1:0]  adc_value,
    input  logic              adc_hit,
    input  logic              adc_gain,
    output logic              adc_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_data,
    output logic              mem_we,
    output logic              done,
    output logic [ADDR_W-1:0] word_count
);

    phase_t          phase;
    logic [ID_W-1:0] id_q;
    adc_beat_t       beat;

    assign beat.hit   = adc_hit;
    assign beat.gain  = adc_gain;
    assign beat.value = adc_value;

    always_ff @(posedge clk) begin
        if (rst) begin
            id_q <= '0;
        end else if (start && phase == PH_IDLE) begin
            id_q <= chip_id;
        end
    end

    evtfw_ctrl #(.N_CH(N_CH), .MAX_EVT(MAX_EVT)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .evt_count  (evt_count),
        .adc_valid  (adc_valid),
        .phase      (phase),
        .evt_idx    (ts_addr),
        .wr_addr    (mem_addr),
        .we         (mem_we),
        .adc_ready  (adc_ready),
        .done       (done),
        .word_count (word_count)
    );

    evtfw_fmt u_fmt (
        .phase   (phase),
        .chip_id (id_q),
        .ts_data (ts_data),
        .beat    (beat),
        .word    (mem_data)
    );

    // R4
    pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && phase == PH_CH) |-> (mem_data[WORD_W-1:ADC_W+2] == '0));

    // R1
    id_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_addr == '0) |-> (mem_data[WORD_W-1:ID_W] == '0));

endmodule

// File: tb/test_evt_frame_writer.sv
module test_evt_frame_writer;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [7:0]  chip_id;
    logic [2:0]  evt_count;
    logic [2:0]  ts_addr;
    logic [11:0] ts_data;
    logic        adc_valid;
    logic [11:0] adc_value;
    logic        adc_hit;
    logic        adc_gain;
    logic        adc_ready;
    logic [7:0]  mem_addr;
    logic [15:0] mem_data;
    logic        mem_we;
    logic        done;
    logic [7:0]  word_count;

    logic [11:0] ts_mem [0:7];
    int errors = 0;
    int checks = 0;
    int cycles = 0;

    assign ts_data = ts_mem[ts_addr];

    always #2 clk = ~clk;

    evt_frame_writer i_evt_frame_writer (
        .clk(clk), .rst(rst), .start(start), .chip_id(chip_id),
        .evt_count(evt_count), .ts_addr(ts_addr), .ts_data(ts_data),
        .adc_valid(adc_valid), .adc_value(adc_value), .adc_hit(adc_hit),
        .adc_gain(adc_gain), .adc_ready(adc_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_we(mem_we), .done(done),
        .word_count(word_count)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] beat_word(input int idx, input int seed);
        logic [11:0] v;
        v = 12'((idx * 37 + seed * 101) & 12'hFFF);
        return {2'b00, 1'(idx ^ seed), 1'(idx >> 1), v};
    endfunction

    function automatic bit gap_valid(input int mode, input int cyc);
        case (mode)
            0: return 1'b1;
            1: return cyc[0];
            default: return (cyc % 5) != 0;
        endcase
    endfunction

    task automatic run_frame(input int n_req, input logic [7:0] chip, input int gap,
                             input bit poke_start, input int seed);
        int n;
        int total;
        int exp_addr;
        int k;
        bit id_done;
        bit finished;
        bit last_we;
        bit exp_ready;
        logic [15:0] exp_d;
        n = (n_req > 5) ? 5 : n_req;
        total = 1 + 37 * n;
        exp_addr = 0;
        k = 0;
        id_done = 0;
        finished = 0;
        last_we = 0;
        for (int i = 0; i < 8; i++) ts_mem[i] = 12'((seed * 523 + i * 97 + 5) & 12'hFFF);
        @(negedge clk);
        chip_id = chip;
        evt_count = 3'(n_req);
        start = 1'b1;
        adc_valid = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chip_id = ~chip;
        evt_count = 3'd7;
        for (int cyc = 0; cyc < 3000 && !finished; cyc++) begin
            adc_valid = gap_valid(gap, cyc);
            {adc_hit, adc_gain, adc_value} = beat_word(k, seed)[13:0];
            start = poke_start && (cyc == 3 || cyc == 2 + n + 4);
            #1;
            exp_ready = id_done && exp_addr >= 1 + n && exp_addr < total;
            chk(adc_ready === exp_ready, "R5 adc_ready", adc_ready, exp_ready);
            if (exp_ready)
                chk(mem_we === adc_valid, "R5 write follows valid", mem_we, adc_valid);
            if (mem_we) begin
                chk(exp_addr < total, "R7 no write past frame end", exp_addr, total);
                chk(mem_addr === 8'(exp_addr), "R1/R2/R3 address", mem_addr, exp_addr);
                if (exp_addr == 0) begin
                    exp_d = {8'h00, chip};
                    chk(mem_data === exp_d, "R1 chip-ID word", mem_data, exp_d);
                    id_done = 1;
                end else if (exp_addr < 1 + n) begin
                    exp_d = {4'h0, ts_mem[exp_addr - 1]};
                    chk(mem_data === exp_d, "R2 timestamp word", mem_data, exp_d);
                    chk(ts_addr === 3'(exp_addr - 1), "R2 ts_addr", ts_addr, exp_addr - 1);
                end else begin
                    exp_d = beat_word(exp_addr - 1 - n, seed);
                    chk(mem_data === exp_d, "R3 R4 channel word", mem_data, exp_d);
                end
                exp_addr++;
            end else if (id_done && exp_addr < 1 + n) begin
                chk(0, "R2 timestamps contiguous", 0, 1);
            end
            if (adc_valid && adc_ready) k++;
            if (done) begin
                chk(last_we && !mem_we, "R7 done right after last write", last_we, 1);
                chk(exp_addr == total, "R6 R7 R8 words at done", exp_addr, total);
                chk(word_count === 8'(total), "R7 word_count", word_count, total);
                finished = 1;
            end
            last_we = mem_we;
            @(negedge clk);
        end
        start = 1'b0;
        adc_valid = 1'b0;
        chk(finished, "R7 done reached", finished, 1);
        #1;
        chk(done === 1'b0, "R7 done one cycle", done, 0);
        chk(mem_we === 1'b0, "R7 idle after frame", mem_we, 0);
        chk(word_count === 8'(total), "R7 word_count held", word_count, total);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        start = 1'b0;
        adc_valid = 1'b1;
        chip_id = 8'h00;
        evt_count = 3'd0;
        adc_value = 12'h0;
        adc_hit = 1'b0;
        adc_gain = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(mem_we === 1'b0, "R10 mem_we after reset", mem_we, 0);
        chk(adc_ready === 1'b0, "R10 adc_ready after reset", adc_ready, 0);
        chk(done === 1'b0, "R10 done after reset", done, 0);
        chk(word_count === 8'd0, "R10 word_count after reset", word_count, 0);
        adc_valid = 1'b0;
    endtask

    task automatic test_full_rate();   run_frame(5, 8'hA5, 0, 0, 1); endtask
    task automatic test_half_rate();   run_frame(2, 8'h3C, 1, 0, 2); endtask
    task automatic test_sparse();      run_frame(3, 8'hFF, 2, 0, 3); endtask
    task automatic test_empty();       run_frame(0, 8'h81, 0, 0, 4); endtask
    task automatic test_clamp();       run_frame(7, 8'h5A, 2, 0, 5); endtask
    task automatic test_busy_start();  run_frame(1, 8'h12, 1, 1, 6); endtask

    initial begin
        for (int i = 0; i < 8; i++) ts_mem[i] = 12'h0;
        test_reset();
        test_full_rate();
        test_half_rate();
        test_sparse();
        test_empty();
        test_clamp();
        test_busy_start();
        test_full_rate();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule